// File: doc/BRIEF.md
# Subroutine-Call Bus Sequencer

This block drives the memory bus for one subroutine-call instruction of an 8-bit processor. The processor's decode logic raises a one-cycle start request with the program counter still pointing at the call opcode and with the current stack pointer. The sequencer then produces a fixed series of byte-wide memory operations over six clock cycles. It reads the low byte of the call target. It waits one internal cycle. It pushes the high byte and then the low byte of the return address onto a descending stack that lives in page $01. Last, it reads the high byte of the target. In the sixth cycle it raises a one-cycle done pulse with the program counter already holding the target.

The return address pushed on the stack is the address of the last operand byte, which is the opcode address plus 2. The high byte of the target is read only after both pushes. If the operand sits inside the stack page, at a location that a push has just written, the read returns the byte that was just pushed and not the byte that was there before the call. Address arithmetic on the program counter wraps at 16 bits. The 8-bit stack pointer wraps from $00 to $FF.

The state machine has seven states. `ST_IDLE` waits for a start request; a start taken there leads to `ST_TGT_LO`. The other transitions have no condition and run in order: `ST_TGT_LO` → `ST_GAP` → `ST_PUSH_HI` → `ST_PUSH_LO` → `ST_TGT_HI` → `ST_FINISH` → `ST_IDLE`.

Top module: `call_sequencer`

## Requirements
- R1: After reset the block is idle. `busy_o` and `done_o` are 0, neither `bus_rd_o` nor `bus_wr_o` is asserted, and no bus operation occurs while idle.
- R2: In the first cycle after a start is accepted, the block reads one byte at opcode address + 1 (modulo 2^16). That byte is kept as the target low byte.
- R3: The second cycle is an internal cycle with neither a read nor a write on the bus.
- R4: The third cycle writes bits [15:8] of the return address (opcode address + 2) to address {$01, SP}. SP is then decremented.
- R5: The fourth cycle writes bits [7:0] of the return address to address {$01, SP-1}. SP is decremented again, and 8-bit SP arithmetic wraps from $00 to $FF.
- R6: The fifth cycle reads the target high byte at opcode address + 2. The read happens after both pushes, so an operand in a just-written stack location returns the pushed value.
- R7: In the sixth cycle `done_o` is 1 for exactly one cycle. At that point `pc_o` equals {high byte, low byte} and `sp_o` equals the starting SP minus 2 (mod 256). The block is idle in the following cycle.
- R8: A start request raised while a call is in progress is ignored. The bus sequence, the final PC and the final SP come from the accepted request only.
- R9: When the opcode address is $FFFE or $FFFF, the operand addresses wrap through $0000, and the pushed return address wraps the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Call request, taken only while idle |
| pc_i | input | 16 | Address of the call opcode |
| sp_i | input | 8 | Stack pointer at the time of the call |
| bus_addr_o | output | 16 | Memory address of the current operation |
| bus_rd_o | output | 1 | Read strobe; data is expected on bus_rdata_i in the same cycle |
| bus_wr_o | output | 1 | Write strobe |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data from memory |
| pc_o | output | 16 | Program counter; holds the opcode address during a call and the target from the done cycle on |
| sp_o | output | 8 | Stack pointer |
| busy_o | output | 1 | A call is in progress |
| done_o | output | 1 | One-cycle pulse in the last cycle of a call |

## Verification
The bus outputs are decoded directly from the current state, so a wrong state shows up at the ports in the same cycle. Examples are a skipped idle cycle, a swapped push order or an early high-byte read. Each such error appears as a wrong strobe, address or data byte in one of the six cycles. A wrong stack pointer update shows as a wrong push address in the very next push and as a wrong `sp_o` at the done pulse. A high byte read too early is exposed only when the operand overlaps a push location, because only then does the returned byte differ.

// File: rtl/call_seq_pkg.sv
package call_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_TGT_LO  = 3'd1,
        ST_GAP     = 3'd2,
        ST_PUSH_HI = 3'd3,
        ST_PUSH_LO = 3'd4,
        ST_TGT_HI  = 3'd5,
        ST_FINISH  = 3'd6
    } call_state_e;

endpackage

// File: rtl/call_seq_fsm.sv
module call_seq_fsm
    import call_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output call_state_e state_o
);

    call_state_e state_q;
    call_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: only the idle state has a condition
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = start_i ? ST_TGT_LO : ST_IDLE;
            ST_TGT_LO:  state_d = ST_GAP;
            ST_GAP:     state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_TGT_HI;
            ST_TGT_HI:  state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/call_seq_regs.sv
module call_seq_regs
    import call_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  call_state_e       state_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] sp_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] sp_o,
    output logic [DATA_W-1:0] tgt_lo_o
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            sp_q <= '0;
            lo_q <= '0;
        end else begin
            unique case (state_i)
                ST_IDLE: begin
                    if (start_i) begin
                        pc_q <= pc_i;
                        sp_q <= sp_i;
                    end
                end
                ST_TGT_LO:  lo_q <= rdata_i;
                ST_PUSH_HI: sp_q <= sp_q - DATA_W'(1);
                ST_PUSH_LO: sp_q <= sp_q - DATA_W'(1);
                ST_TGT_HI:  pc_q <= {rdata_i[HI_W-1:0], lo_q};
                default: begin
                end
            endcase
        end
    end

    assign pc_o     = pc_q;
    assign sp_o     = sp_q;
    assign tgt_lo_o = lo_q;

endmodule

// File: rtl/call_seq_bus.sv
module call_seq_bus
    import call_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01
) (
    input  call_state_e       state_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] sp_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o
);

    localparam int LO_OFS  = 1;
    localparam int RET_OFS = LO_OFS + 1;

    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] stack_addr;

    assign ret_addr   = pc_i + ADDR_W'(RET_OFS);
    assign stack_addr = {STACK_PAGE, sp_i};

    // outputs decoded from the current state only
    always_comb begin
        addr_o  = '0;
        rd_o    = 1'b0;
        wr_o    = 1'b0;
        wdata_o = '0;
        unique case (state_i)
            ST_TGT_LO: begin
                addr_o = pc_i + ADDR_W'(LO_OFS);
                rd_o   = 1'b1;
            end
            ST_PUSH_HI: begin
                addr_o  = stack_addr;
                wr_o    = 1'b1;
                wdata_o = ret_addr[ADDR_W-1:ADDR_W-DATA_W];
            end
            ST_PUSH_LO: begin
                addr_o  = stack_addr;
                wr_o    = 1'b1;
                wdata_o = ret_addr[DATA_W-1:0];
            end
            ST_TGT_HI: begin
                addr_o = ret_addr;
                rd_o   = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/call_sequencer.sv
module call_sequencer
    import call_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] sp_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] sp_o,
    output logic              busy_o,
    output logic              done_o
);

    call_state_e       state;
    logic [DATA_W-1:0] tgt_lo;

    call_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .state_o (state)
    );

    call_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (state),
        .start_i  (start_i),
        .pc_i     (pc_i),
        .sp_i     (sp_i),
        .rdata_i  (bus_rdata_i),
        .pc_o     (pc_o),
        .sp_o     (sp_o),
        .tgt_lo_o (tgt_lo)
    );

    call_seq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .state_i (state),
        .pc_i    (pc_o),
        .sp_i    (sp_o),
        .addr_o  (bus_addr_o),
        .rd_o    (bus_rd_o),
        .wr_o    (bus_wr_o),
        .wdata_o (bus_wdata_o)
    );

    always_comb begin
        busy_o = (state != ST_IDLE);
        done_o = (state == ST_FINISH);
    end

    logic unused_lo;
    assign unused_lo = ^tgt_lo;

endmodule

// File: rtl/call_sequencer_chk.sv
module call_sequencer_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_rd_o,
    input logic              bus_wr_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic              busy_o,
    input logic              done_o
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!bus_rd_o && !bus_wr_o));

    // R2
    first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (bus_rd_o && bus_addr_o == pc_o + ADDR_W'(1)));

    // R3
    gap_before_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_o && !$past(bus_wr_o)) |-> (!$past(bus_rd_o) && $past(busy_o)));

    // R4
    stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_o |-> (bus_addr_o[ADDR_W-1:DATA_W] == (ADDR_W-DATA_W)'(1)));

    // R5
    push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_o && $past(bus_wr_o)) |->
            (bus_addr_o[DATA_W-1:0] == $past(bus_addr_o[DATA_W-1:0]) - DATA_W'(1)));

    // R6
    late_high_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o && $past(bus_wr_o)) |-> (bus_addr_o == pc_o + ADDR_W'(2)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R7
    done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(bus_rd_o) && busy_o));

endmodule

bind call_sequencer call_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr_o (bus_addr_o),
    .bus_rd_o   (bus_rd_o),
    .bus_wr_o   (bus_wr_o),
    .pc_o       (pc_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/call_sequencer_tb.sv
`timescale 1ns/1ps
module call_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [7:0]  sp_i = '0;
    logic [15:0] bus_addr_o;
    logic        bus_rd_o;
    logic        bus_wr_o;
    logic [7:0]  bus_wdata_o;
    logic [7:0]  bus_rdata_i;
    logic [15:0] pc_o;
    logic [7:0]  sp_o;
    logic        busy_o;
    logic        done_o;

    logic [7:0] mem [0:65535];

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    call_sequencer u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .pc_i (pc_i), .sp_i (sp_i),
        .bus_addr_o (bus_addr_o), .bus_rd_o (bus_rd_o), .bus_wr_o (bus_wr_o),
        .bus_wdata_o (bus_wdata_o), .bus_rdata_i (bus_rdata_i),
        .pc_o (pc_o), .sp_o (sp_o), .busy_o (busy_o), .done_o (done_o)
    );

    assign bus_rdata_i = mem[bus_addr_o];

    always @(posedge clk) begin
        if (bus_wr_o) mem[bus_addr_o] <= bus_wdata_o;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one call; intrude=1 raises a second start while busy (R8)
    task automatic do_call(input logic [15:0] pc, input logic [7:0] sp,
                           input logic [7:0] lo, input logic [7:0] hi, input bit intrude);
        logic [15:0] ret;
        logic [15:0] a_hi;
        logic [15:0] a_lo;
        logic [7:0]  exp_hi;
        ret  = pc + 16'd2;
        a_hi = {8'h01, sp};
        a_lo = {8'h01, sp - 8'd1};
        mem[pc + 16'd1] = lo;
        mem[pc + 16'd2] = hi;
        if (ret == a_lo)      exp_hi = ret[7:0];
        else if (ret == a_hi) exp_hi = ret[15:8];
        else                  exp_hi = hi;
        start_i = 1'b1; pc_i = pc; sp_i = sp;
        @(negedge clk);
        if (intrude) begin
            pc_i = pc ^ 16'h5A5A; sp_i = sp ^ 8'h33;
        end else begin
            start_i = 1'b0;
        end
        // R2 / R9 cycle 1
        chk(bus_rd_o && !bus_wr_o && bus_addr_o == pc + 16'd1, "R2", bus_addr_o, pc + 16'd1);
        @(negedge clk);
        // R3 cycle 2
        chk(!bus_rd_o && !bus_wr_o, "R3", {bus_rd_o, bus_wr_o}, 0);
        @(negedge clk);
        start_i = 1'b0;
        // R4 cycle 3
        chk(bus_wr_o && bus_addr_o == a_hi, "R4 addr", bus_addr_o, a_hi);
        chk(bus_wdata_o == ret[15:8], "R4 data", bus_wdata_o, ret[15:8]);
        @(negedge clk);
        // R5 cycle 4
        chk(bus_wr_o && bus_addr_o == a_lo, "R5 addr", bus_addr_o, a_lo);
        chk(bus_wdata_o == ret[7:0], "R5 data", bus_wdata_o, ret[7:0]);
        @(negedge clk);
        // R6 cycle 5
        chk(bus_rd_o && !bus_wr_o && bus_addr_o == ret, "R6 addr", bus_addr_o, ret);
        chk(bus_rdata_i == exp_hi, "R6 data", bus_rdata_i, exp_hi);
        @(negedge clk);
        // R7 / R8 cycle 6
        chk(done_o == 1'b1, "R7 done", done_o, 1);
        chk(pc_o == {exp_hi, lo}, "R7 pc", pc_o, {exp_hi, lo});
        chk(sp_o == sp - 8'd2, "R7 sp", sp_o, sp - 8'd2);
        @(negedge clk);
        chk(!done_o && !busy_o, "R7 end", {done_o, busy_o}, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !bus_rd_o && !bus_wr_o, "R1",
            {busy_o, done_o, bus_rd_o, bus_wr_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !bus_rd_o && !bus_wr_o, "R1 idle", {busy_o, bus_rd_o, bus_wr_o}, 0);
        // sweep of PC and SP values, wraps included (R5)
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 8; s++) begin
                logic [15:0] pc;
                logic [7:0]  sp;
                pc = 16'(p * 16'h2345 + 16'h0400);
                sp = (s == 0) ? 8'h00 : (s == 1) ? 8'h01 : (s == 2) ? 8'hFF : 8'(s * 37);
                do_call(pc, sp, 8'(p * 11 + s), 8'(p * 5 + s * 3 + 1), 1'b0);
            end
        end
        // R9 opcode at the top of memory
        do_call(16'hFFFE, 8'hFD, 8'h12, 8'h34, 1'b0);
        do_call(16'hFFFF, 8'h80, 8'h56, 8'h78, 1'b0);
        // R6 operand high byte at the location of the second push
        do_call(16'h01F0, 8'hF3, 8'hAA, 8'hBB, 1'b0);
        // R6 operand high byte at the location of the first push
        do_call(16'h01E0, 8'hE2, 8'hCC, 8'hDD, 1'b0);
        // R6 with SP wrap and overlap at $01FF
        do_call(16'h01FD, 8'h00, 8'h11, 8'h22, 1'b0);
        // R8 start held with other values while busy
        do_call(16'h3000, 8'h40, 8'h9A, 8'hBC, 1'b1);
        do_call(16'h0100, 8'h02, 8'h01, 8'h02, 1'b1);
        // R1 quiet while idle with no start
        repeat (4) begin
            @(negedge clk);
            chk(!busy_o && !bus_rd_o && !bus_wr_o, "R1 quiet", {busy_o, bus_rd_o, bus_wr_o}, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule